// File: doc/BRIEF.md
# Block Lock-Bit Command Controller

This block sits in the command path of a flash memory and holds one lock flag for each erase block. It watches bus write cycles of address and data. A two-write sequence that begins with a common setup code changes the lock flags. The confirm code chosen in the second write decides what happens: either one block is locked, or every lock flag is cleared at once. No command unlocks a single block.

The controller reports through an 8-bit status byte and a ready line. It also drives a status-read flag that tells the read path to return status instead of array data. While the selected operation runs, the controller holds busy for a fixed number of cycles.

Two interlocks refuse a lock change. The first refuses it while the rest of the device is busy or suspended. The second refuses it while the program-enable voltage is at or below its lockout level. A query port and a program/erase gate read the lock flags, so that the execution logic can refuse erase or program requests to locked blocks.

The lock flags model non-volatile cells. They are cleared only by the power-on reset, which stands for the factory state of all blocks unlocked. A soft reset returns the sequencer and the status byte to idle and keeps every lock flag.

Top module: `lock_cmd_ctrl`

## Requirements

The status byte uses these bit positions:
- bit 7 is ready.
- bit 5 is the clear-sequence error.
- bit 4 is the lock-sequence error.
- bit 3 is the voltage error.
- All other bits read 0.

Command codes are compared on the full data word: setup 0060h, lock confirm 0001h, clear-all confirm 00D0h, return to array reads 00FFh, clear status 0050h.

- R1: A write of 0060h followed by a write of 0001h locks only the block that holds the address of the confirm write. The block index is address bits [ADDR_W-1:BLK_SHIFT]. The new lock becomes visible in the same cycle that ready returns high.
- R2: A write of 0060h followed by a write of 00D0h to any address clears every lock flag when the operation completes.
- R3: The setup write raises `stat_mode` on the next cycle. A write of 00FFh while idle lowers it.
- R4: After an accepted confirm, `ready` and status bit 7 read 0 for exactly OP_CYCLES cycles and then read 1.
- R5: `pe_refuse` is high exactly when `pe_req` is high and the block of `pe_addr` is locked. `pe_allow` is high exactly when `pe_req` is high and that block is unlocked. `qry_locked` gives the lock flag of the block of `qry_addr`.
- R6: If `busy_in` is high at a valid confirm, the lock flags stay unchanged and no busy period follows. A refused lock sequence sets status bit 4. A refused clear sequence sets status bit 5.
- R7: If `vpp_ok` is low at a valid confirm, the lock flags stay unchanged. Status bit 3 is set together with the bit 4 or bit 5 that belongs to the sequence.
- R8: Any confirm data other than 0001h or 00D0h aborts the sequence. The lock flags stay unchanged, status bits 4 and 5 are both set, and the next 0060h starts a new sequence.
- R9: `rst_n` leaves the lock flags unchanged and sets the status byte to 80h and `stat_mode` to 0. `por_n` clears every lock flag.
- R10: Writes issued while the operation is busy have no effect on lock flags, status or `stat_mode`.
- R11: A write of 0050h while idle clears status bits 3, 4 and 5. The error bits otherwise stay set until this write or a reset.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears all lock flags and the sequencer |
| rst_n | input | 1 | Soft reset, active low; sequencer and status only |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data (command code) |
| busy_in | input | 1 | Program/erase running or device suspended |
| vpp_ok | input | 1 | Program-enable voltage above lockout level |
| qry_addr | input | ADDR_W | Address for lock query |
| qry_locked | output | 1 | Lock flag of the queried block |
| pe_req | input | 1 | Program or erase request |
| pe_addr | input | ADDR_W | Target address of the request |
| pe_refuse | output | 1 | Request targets a locked block |
| pe_allow | output | 1 | Request targets an unlocked block |
| ready | output | 1 | Lock operation not in progress |
| stat_mode | output | 1 | Reads should return the status byte |
| status | output | 8 | Status byte |

## Verification

Suppose the sequencer holds a wrong pending block index or operation kind. That error reaches the ports only when the busy period ends, OP_CYCLES cycles after the confirm. At that point the lock query scan shows a wrong block locked, or shows flags that survived a clear.

A wrong busy counter shows at once: `ready` rises early or late against the cycle count the bench computes from the confirm edge. A missed interlock shows as a busy period that should not exist, and as a lock flag that changes when it should not. Sticky error flags that are set or cleared wrongly are visible in `status` on the cycle after the confirm or the clear-status write.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_RUN   = 2'd2
  } lcc_state_e;

  localparam logic [15:0] CMD_SETUP  = 16'h0060;
  localparam logic [15:0] CMD_LOCK   = 16'h0001;
  localparam logic [15:0] CMD_CLRALL = 16'h00D0;
  localparam logic [15:0] CMD_ARRAY  = 16'h00FF;
  localparam logic [15:0] CMD_CLRSR  = 16'h0050;

  localparam int SR_READY = 7;
  localparam int SR_CLRER = 5;
  localparam int SR_LCKER = 4;
  localparam int SR_VPPER = 3;
endpackage

// File: rtl/lcc_seq.sv
module lcc_seq
  import lcc_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int BLK_W     = 6,
  parameter int OP_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             busy_in,
  input  logic             vpp_ok,
  output logic             go_evt,
  output logic             bad_evt,
  output logic             err_set_evt,
  output logic             err_clr_evt,
  output logic             err_vpp_evt,
  output logic             clr_sr_evt,
  output logic             apply_set,
  output logic             apply_clr,
  output logic [BLK_W-1:0] apply_idx,
  output logic             run_o,
  output logic             stat_mode_o
);
  localparam int CNT_W = $clog2(OP_CYCLES + 1);

  lcc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_clr_q;
  logic [BLK_W-1:0] pend_idx_q;
  logic             mode_q;

  function automatic logic code_is(input logic [DATA_W-1:0] d, input logic [15:0] c);
    return d == DATA_W'(c);
  endfunction

  logic is_setup, is_lock, is_clr, is_array, is_clrsr, is_valid_cfm;
  logic idle_wr, cfm, interlock_ok, done;

  assign is_setup     = code_is(wr_data, CMD_SETUP);
  assign is_lock      = code_is(wr_data, CMD_LOCK);
  assign is_clr       = code_is(wr_data, CMD_CLRALL);
  assign is_array     = code_is(wr_data, CMD_ARRAY);
  assign is_clrsr     = code_is(wr_data, CMD_CLRSR);
  assign is_valid_cfm = is_lock | is_clr;

  assign idle_wr      = (state_q == ST_IDLE) && wr_en;
  assign cfm          = (state_q == ST_SETUP) && wr_en;
  assign interlock_ok = !busy_in && vpp_ok;
  assign done         = (state_q == ST_RUN) && (cnt_q == '0);

  assign go_evt      = cfm && is_valid_cfm && interlock_ok;
  assign bad_evt     = cfm && !is_valid_cfm;
  assign err_set_evt = cfm && is_lock && !interlock_ok;
  assign err_clr_evt = cfm && is_clr && !interlock_ok;
  assign err_vpp_evt = cfm && is_valid_cfm && !vpp_ok;
  assign clr_sr_evt  = idle_wr && is_clrsr;

  assign apply_set   = done && !pend_clr_q;
  assign apply_clr   = done && pend_clr_q;
  assign apply_idx   = pend_idx_q;
  assign run_o       = (state_q == ST_RUN);
  assign stat_mode_o = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      pend_clr_q <= 1'b0;
      pend_idx_q <= '0;
      mode_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (idle_wr && is_setup) begin
            state_q <= ST_SETUP;
            mode_q  <= 1'b1;
          end else if (idle_wr && is_array) begin
            mode_q  <= 1'b0;
          end
        end
        ST_SETUP: begin
          if (go_evt) begin
            state_q    <= ST_RUN;
            cnt_q      <= CNT_W'(OP_CYCLES - 1);
            pend_clr_q <= is_clr;
            pend_idx_q <= wr_blk;
          end else if (wr_en) begin
            state_q <= ST_IDLE;
          end
        end
        ST_RUN: begin
          if (done) state_q <= ST_IDLE;
          else      cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  go_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_evt |=> run_o);

  // R10
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !done) |=> (run_o && stat_mode_o));
endmodule

// File: rtl/lcc_status.sv
module lcc_status
  import lcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       bad_evt,
  input  logic       err_set_evt,
  input  logic       err_clr_evt,
  input  logic       err_vpp_evt,
  input  logic       clr_sr_evt,
  output logic [7:0] sr_o
);
  logic lck_er_q, clr_er_q, vpp_er_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lck_er_q <= 1'b0;
      clr_er_q <= 1'b0;
      vpp_er_q <= 1'b0;
    end else if (clr_sr_evt) begin
      lck_er_q <= 1'b0;
      clr_er_q <= 1'b0;
      vpp_er_q <= 1'b0;
    end else begin
      lck_er_q <= lck_er_q | err_set_evt | bad_evt;
      clr_er_q <= clr_er_q | err_clr_evt | bad_evt;
      vpp_er_q <= vpp_er_q | err_vpp_evt;
    end
  end

  always_comb begin
    sr_o           = 8'h00;
    sr_o[SR_READY] = !run_i;
    sr_o[SR_CLRER] = clr_er_q;
    sr_o[SR_LCKER] = lck_er_q;
    sr_o[SR_VPPER] = vpp_er_q;
  end

  // R8
  bad_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> (sr_o[SR_CLRER] && sr_o[SR_LCKER]));

  // R11
  clr_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sr_evt |=> (sr_o[5:3] == 3'b000));

  // R7
  vpp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_vpp_evt |=> sr_o[SR_VPPER]);
endmodule

// File: rtl/lcc_lockbits.sv
module lcc_lockbits #(
  parameter int BLK_W = 6,
  localparam int NBLK = 1 << BLK_W
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             apply_set,
  input  logic             apply_clr,
  input  logic [BLK_W-1:0] set_idx,
  input  logic [BLK_W-1:0] qry_idx,
  input  logic [BLK_W-1:0] pe_idx,
  output logic             qry_locked,
  output logic             pe_locked
);
  logic [NBLK-1:0] bits_q;

  for (genvar g = 0; g < NBLK; g++) begin : g_cell
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                                            bits_q[g] <= 1'b0;
      else if (apply_clr)                                    bits_q[g] <= 1'b0;
      else if (apply_set && (set_idx == BLK_W'(g)))          bits_q[g] <= 1'b1;
    end
  end

  assign qry_locked = bits_q[qry_idx];
  assign pe_locked  = bits_q[pe_idx];

  // R1
  set_take_chk: assert property (@(posedge clk) disable iff (!por_n)
    apply_set |=> bits_q[$past(set_idx)]);

  // R2
  clr_all_chk: assert property (@(posedge clk) disable iff (!por_n)
    apply_clr |=> (bits_q == '0));

  // R9
  hold_bits_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!apply_set && !apply_clr) |=> $stable(bits_q));
endmodule

// File: rtl/lock_cmd_ctrl.sv
module lock_cmd_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int BLK_SHIFT = 10,
  parameter int OP_CYCLES = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy_in,
  input  logic              vpp_ok,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_locked,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] pe_addr,
  output logic              pe_refuse,
  output logic              pe_allow,
  output logic              ready,
  output logic              stat_mode,
  output logic [7:0]        status
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:BLK_SHIFT];
  endfunction

  logic             seq_rst_n;
  logic             go_evt, bad_evt, err_set_evt, err_clr_evt, err_vpp_evt, clr_sr_evt;
  logic             apply_set, apply_clr, run;
  logic [BLK_W-1:0] apply_idx;
  logic             pe_locked;

  assign seq_rst_n = rst_n & por_n;

  lcc_seq #(.DATA_W(DATA_W), .BLK_W(BLK_W), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk(clk), .rst_n(seq_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_blk(blk_of(wr_addr)), .busy_in(busy_in), .vpp_ok(vpp_ok),
    .go_evt(go_evt), .bad_evt(bad_evt), .err_set_evt(err_set_evt),
    .err_clr_evt(err_clr_evt), .err_vpp_evt(err_vpp_evt), .clr_sr_evt(clr_sr_evt),
    .apply_set(apply_set), .apply_clr(apply_clr), .apply_idx(apply_idx),
    .run_o(run), .stat_mode_o(stat_mode)
  );

  lcc_status u_status (
    .clk(clk), .rst_n(seq_rst_n), .run_i(run), .bad_evt(bad_evt),
    .err_set_evt(err_set_evt), .err_clr_evt(err_clr_evt),
    .err_vpp_evt(err_vpp_evt), .clr_sr_evt(clr_sr_evt), .sr_o(status)
  );

  lcc_lockbits #(.BLK_W(BLK_W)) u_bits (
    .clk(clk), .por_n(por_n), .apply_set(apply_set), .apply_clr(apply_clr),
    .set_idx(apply_idx), .qry_idx(blk_of(qry_addr)), .pe_idx(blk_of(pe_addr)),
    .qry_locked(qry_locked), .pe_locked(pe_locked)
  );

  assign ready     = !run;
  assign pe_refuse = pe_req && pe_locked;
  assign pe_allow  = pe_req && !pe_locked;

  // R5
  pe_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
    !(pe_refuse && pe_allow));

  // R6
  refuse_quiet_chk: assert property (@(posedge clk) disable iff (!seq_rst_n)
    (err_set_evt || err_clr_evt) |=> ready);
endmodule

// File: tb/lock_cmd_ctrl_tb.sv
module lock_cmd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16, DATA_W = 16, BLK_SHIFT = 10, OP_CYCLES = 8;
  localparam int NBLK = 1 << (ADDR_W - BLK_SHIFT);

  logic clk = 1'b0, por_n = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, busy_in = 1'b0, vpp_ok = 1'b1, pe_req = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, qry_addr = '0, pe_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic qry_locked, pe_refuse, pe_allow, ready, stat_mode;
  logic [7:0] status;

  int checks = 0, errors = 0, cyc = 0;
  bit exp_lock [NBLK];
  bit e5 = 0, e4 = 0, e3 = 0;

  lock_cmd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_SHIFT(BLK_SHIFT), .OP_CYCLES(OP_CYCLES)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy_in(busy_in), .vpp_ok(vpp_ok), .qry_addr(qry_addr),
    .qry_locked(qry_locked), .pe_req(pe_req), .pe_addr(pe_addr),
    .pe_refuse(pe_refuse), .pe_allow(pe_allow), .ready(ready),
    .stat_mode(stat_mode), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R4 actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] exp_sr(input bit rdy);
    return {rdy, 1'b0, e5, e4, e3, 3'b000};
  endfunction

  function automatic logic [ADDR_W-1:0] addr_in(input int blk);
    return ADDR_W'((blk << BLK_SHIFT) | ($urandom % (1 << BLK_SHIFT)));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < OP_CYCLES + 2 && !ready; i++) @(negedge clk);
  endtask

  task automatic scan(input string req);
    for (int b = 0; b < NBLK; b++) begin
      qry_addr = addr_in(b);
      #1;
      chk(qry_locked == exp_lock[b], req, qry_locked, exp_lock[b]);
    end
  endtask

  task automatic chk_sr(input string req);
    chk(status == exp_sr(ready), req, status, exp_sr(ready));
  endtask

  task automatic clr_sr();
    wr(16'h0000, 16'h0050);
    e5 = 0; e4 = 0; e3 = 0;
  endtask

  // kind 0 lock, 1 clear-all, 2 bad confirm
  task automatic do_op(input int kind, input int blk, input bit bsy, input bit vok);
    logic [DATA_W-1:0] c;
    c = (kind == 0) ? 16'h0001 : (kind == 1) ? 16'h00D0 : 16'h0077;
    wr(addr_in(blk), 16'h0060);
    busy_in = bsy; vpp_ok = vok;
    wr(addr_in(blk), c);
    busy_in = 1'b0; vpp_ok = 1'b1;
    if (kind == 2) begin e4 = 1; e5 = 1; end
    else if (bsy || !vok) begin
      if (kind == 0) e4 = 1; else e5 = 1;
      if (!vok) e3 = 1;
    end else if (kind == 0) exp_lock[blk] = 1;
    else for (int b = 0; b < NBLK; b++) exp_lock[b] = 0;
    wait_ready();
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int b = 0; b < NBLK; b++) exp_lock[b] = 0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R9 reset ready", ready, 1);
    chk(status == 8'h80, "R9 reset status", status, 8'h80);
    chk(stat_mode == 1'b0, "R9 reset stat_mode", stat_mode, 0);
    scan("R9 reset unlocked");

    // R3 setup raises status mode
    wr(addr_in(5), 16'h0060);
    chk(stat_mode == 1'b1, "R3 setup stat_mode", stat_mode, 1);
    // R1 / R4 lock block 5, busy count
    wr(addr_in(5), 16'h0001);
    exp_lock[5] = 1;
    for (int k = 0; k < OP_CYCLES; k++) begin
      chk(ready == 1'b0 && status[7] == 1'b0, "R4 busy window", {ready, status[7]}, 0);
      if (k == OP_CYCLES - 2) begin
        qry_addr = addr_in(5); #1;
        chk(qry_locked == 1'b0, "R1 not before done", qry_locked, 0);
      end
      @(negedge clk);
    end
    chk(ready == 1'b1 && status == 8'h80, "R4 ready after op", status, 8'h80);
    scan("R1 single block");

    // R5 program/erase gating
    pe_req = 1'b1; pe_addr = addr_in(5); #1;
    chk(pe_refuse && !pe_allow, "R5 refuse locked", {pe_refuse, pe_allow}, 2'b10);
    pe_addr = addr_in(6); #1;
    chk(!pe_refuse && pe_allow, "R5 allow unlocked", {pe_refuse, pe_allow}, 2'b01);
    pe_req = 1'b0; #1;
    chk(!pe_refuse && !pe_allow, "R5 no request", {pe_refuse, pe_allow}, 0);

    // R3 array command drops status mode
    wr(16'h0, 16'h00FF);
    chk(stat_mode == 1'b0, "R3 array mode", stat_mode, 0);

    // R10 writes while busy are ignored
    wr(addr_in(9), 16'h0060);
    wr(addr_in(9), 16'h0001);
    exp_lock[9] = 1;
    wr(16'h0, 16'h00FF);
    wr(addr_in(12), 16'h0060);
    wait_ready();
    chk(stat_mode == 1'b1, "R10 stat_mode kept", stat_mode, 1);
    wr(addr_in(12), 16'h0001);
    chk(ready == 1'b1, "R10 no stray run", ready, 1);
    chk_sr("R10 status");
    scan("R10 locks");

    // R6 busy interlock
    do_op(0, 20, 1'b1, 1'b1);
    chk_sr("R6 busy lock refused");
    scan("R6 locks unchanged");
    do_op(1, 0, 1'b1, 1'b1);
    chk_sr("R6 busy clear refused");
    scan("R6 clear refused");
    // R11
    clr_sr();
    chk(status == 8'h80, "R11 status cleared", status, 8'h80);

    // R7 voltage interlock
    do_op(1, 3, 1'b0, 1'b0);
    chk(status == 8'hA8, "R7 vpp clear", status, 8'hA8);
    scan("R7 locks unchanged");
    clr_sr();

    // R8 bad confirm then fresh sequence
    do_op(2, 30, 1'b0, 1'b1);
    chk(status == 8'hB0, "R8 bad confirm", status, 8'hB0);
    do_op(0, 30, 1'b0, 1'b1);
    chk_sr("R8 restart");
    scan("R8 restart locks");
    clr_sr();

    // R9 soft reset keeps locks
    wr(addr_in(1), 16'h0060);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(status == 8'h80 && stat_mode == 1'b0, "R9 soft reset", {stat_mode, status}, 8'h80);
    scan("R9 locks kept");

    // R2 clear all
    do_op(1, 40, 1'b0, 1'b1);
    scan("R2 clear all");

    // random mix
    for (int it = 0; it < 40; it++) begin
      int kind, blk;
      bit bsy, vok;
      kind = ($urandom % 8 == 0) ? 2 : ($urandom % 5 == 0) ? 1 : 0;
      blk  = $urandom % NBLK;
      bsy  = ($urandom % 8 == 0);
      vok  = ($urandom % 8 != 0);
      do_op(kind, blk, bsy, vok);
      chk_sr("R6 R7 R8 random status");
      for (int q = 0; q < 4; q++) begin
        int b;
        b = $urandom % NBLK;
        qry_addr = addr_in(b); pe_addr = addr_in(b); pe_req = 1'b1; #1;
        chk(qry_locked == exp_lock[b], "R1 R2 random query", qry_locked, exp_lock[b]);
        chk(pe_refuse == exp_lock[b], "R5 random gate", pe_refuse, exp_lock[b]);
        pe_req = 1'b0;
      end
      clr_sr();
    end

    // R9 power-on reset clears
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
    for (int b = 0; b < NBLK; b++) exp_lock[b] = 0;
    scan("R9 por clears");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule